// File: doc/BRIEF.md
# Downstream 1:4 Deserializer with Selectable Parallel Clock

This block sits directly behind clock and data recovery on a continuous downstream serial stream. It runs on the recovered bit clock and samples one serial bit per cycle. It packs each group of `WORD_W` consecutive bits into a parallel word. The earliest bit of a group lands in the top bit of the word. A free-running bit counter, cleared by reset, decides where each group starts. No framing or word alignment is done.

Next to the word the block drives a forwarded parallel clock, in one of two modes:
- **Single-edge mode:** the clock runs at one quarter of the bit rate. The word changes one bit time before each rising edge.
- **Dual-edge mode:** the clock runs at one eighth of the bit rate and toggles once per word. A fresh word is then valid around every edge, rising or falling.

A second clock output serves the upstream side at its word rate. That rate is either equal to the downstream word rate or half of it.

The downstream stream cannot be paused, so the parallel side has no back-pressure. A consumer must take every word around the parallel clock edge that belongs to it, or lose it. The mode inputs are static: change them only while reset is held.

Top module: `down_deser`

## Requirements
- R1: While `rst_n` is low, `pword`, `pclk` and `refclk` are all 0.
- R2: Bits are MSB first: the bit sampled on the first clock edge after reset is released goes to `pword[3]`. The following bits go to `pword[2]`, `pword[1]` and `pword[0]` in turn, and each later group of four repeats that mapping.
- R3: `pword` changes only on the edge that samples the fourth bit of a group, and holds its value for the other three edges of each group.
- R4: With `ddr_mode` = 0, `pclk` has a period of 4 bit clocks, high for 2 and low for 2. It rises exactly one bit clock after each `pword` update.
- R5: With `ddr_mode` = 1, `pclk` toggles once per word, giving a period of 8 bit clocks. Each toggle comes 2 bit clocks after a `pword` update, midway between updates.
- R6: In either mode, `pword` and `pclk` never change on the same clock edge.
- R7: With `up_half` = 0, `refclk` has a period of 4 bit clocks with a 2/2 duty. It rises on the edge that updates `pword`.
- R8: With `up_half` = 1, `refclk` has a period of 8 bit clocks with a 4/4 duty. It changes level on every `pword` update edge and is high during the first word period after reset.
- R9: Asserting reset in the middle of a group discards the partial group. The first bit sampled after release is again the MSB of a new word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdi | input | 1 | Serial downstream data, one bit per clock |
| ddr_mode | input | 1 | 0: single-edge parallel clock at rate/4; 1: dual-edge clock at rate/8 |
| up_half | input | 1 | 0: upstream reference at rate/4; 1: at rate/8 |
| pword | output | WORD_W | Parallel word, MSB is the earliest bit |
| pclk | output | 1 | Forwarded parallel clock |
| refclk | output | 1 | Upstream parallel-rate reference clock |

## Verification
The bench builds the block with the default `WORD_W` of 4. That keeps each group to four bits, so one group walks the counter through every phase. Within a few dozen cycles the bench sees both parallel clock modes, both reference rates and several data patterns, and it computes the expected output for every single edge.

At this width the half-word midpoint for the dual-edge toggle falls on an exact bit clock. A reset placed after six bits lands in the middle of a group, which exercises the discard-and-realign case without long runs.

// File: rtl/deser_pkg.sv
package deser_pkg;
  typedef enum logic {
    PCLK_SINGLE = 1'b0,
    PCLK_DUAL   = 1'b1
  } pclk_mode_e;

  typedef enum logic {
    REF_WORD = 1'b0,
    REF_HALF = 1'b1
  } ref_rate_e;
endpackage

// File: rtl/deser_phase_ctr.sv
module deser_phase_ctr #(
  parameter int WORD_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  output logic [$clog2(WORD_W)-1:0] cnt_q,
  output logic [$clog2(WORD_W)-1:0] cnt_nxt,
  output logic                      wrap,
  output logic                      wpar_nxt
);
  localparam int CW = $clog2(WORD_W);

  logic wpar_q;

  // last bit of a group is sampled while the counter sits at WORD_W-1
  assign wrap     = (cnt_q == CW'(WORD_W - 1));
  assign cnt_nxt  = cnt_q + 1'b1;
  assign wpar_nxt = wpar_q ^ wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wpar_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      wpar_q <= wpar_nxt;
    end
  end
endmodule

// File: rtl/deser_shift.sv
module deser_shift #(
  parameter int WORD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sdi,
  input  logic              wrap,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-2:0] hist_q;
  logic [WORD_W-1:0] gathered;

  // oldest bit ends in the top position
  assign gathered = {hist_q, sdi};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      word_o <= '0;
    end else begin
      hist_q <= gathered[WORD_W-2:0];
      if (wrap) word_o <= gathered;
    end
  end

  assert_hold_between_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(word_o));
endmodule

// File: rtl/deser_clkgen.sv
module deser_clkgen
  import deser_pkg::*;
#(
  parameter int WORD_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  pclk_mode_e                mode,
  input  ref_rate_e                 ref_rate,
  input  logic [$clog2(WORD_W)-1:0] cnt_q,
  input  logic [$clog2(WORD_W)-1:0] cnt_nxt,
  input  logic                      wpar_nxt,
  output logic                      pclk_q,
  output logic                      refclk_q
);
  localparam int CW   = $clog2(WORD_W);
  localparam int HALF = WORD_W / 2;
  localparam int GW   = CW + 1;

  logic pclk_d, refclk_d;

  always_comb begin
    if (mode == PCLK_DUAL)
      pclk_d = pclk_q ^ (cnt_q == CW'(HALF - 1));
    else
      pclk_d = (cnt_q < CW'(HALF));
    if (ref_rate == REF_HALF)
      refclk_d = ~wpar_nxt;
    else
      refclk_d = ~cnt_nxt[CW-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pclk_q   <= 1'b0;
      refclk_q <= 1'b0;
    end else begin
      pclk_q   <= pclk_d;
      refclk_q <= refclk_d;
    end
  end

  // checker: distance between dual-edge toggles must be one word
  logic [GW-1:0] gap_q;
  logic          seen_q, prev_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      prev_q <= pclk_q;
      if (pclk_q != prev_q) begin
        gap_q  <= GW'(1);
        seen_q <= 1'b1;
      end else begin
        gap_q  <= gap_q + 1'b1;
      end
    end
  end

  assert_ddr_period_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PCLK_DUAL && seen_q && pclk_q != prev_q) |-> gap_q == GW'(WORD_W));
endmodule

// File: rtl/down_deser.sv
module down_deser
  import deser_pkg::*;
#(
  parameter int WORD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sdi,
  input  logic              ddr_mode,
  input  logic              up_half,
  output logic [WORD_W-1:0] pword,
  output logic              pclk,
  output logic              refclk
);
  localparam int CW = $clog2(WORD_W);

  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          wrap, wpar_nxt;
  pclk_mode_e    mode;
  ref_rate_e     ref_rate;

  assign mode     = pclk_mode_e'(ddr_mode);
  assign ref_rate = ref_rate_e'(up_half);

  deser_phase_ctr #(.WORD_W(WORD_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .cnt_q(cnt_q), .cnt_nxt(cnt_nxt),
    .wrap(wrap), .wpar_nxt(wpar_nxt)
  );

  deser_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .sdi(sdi), .wrap(wrap), .word_o(pword)
  );

  deser_clkgen #(.WORD_W(WORD_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .mode(mode), .ref_rate(ref_rate),
    .cnt_q(cnt_q), .cnt_nxt(cnt_nxt), .wpar_nxt(wpar_nxt),
    .pclk_q(pclk), .refclk_q(refclk)
  );

  assert_sdr_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ddr_mode && wrap) |-> ##2 $rose(pclk));

  assert_edges_apart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pword) |-> $stable(pclk));

  assert_ref_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!up_half && wrap) |=> $rose(refclk));

  assert_ref_half_flip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (up_half && wrap) |=> !$stable(refclk));
endmodule

// File: tb/sim_down_deser.sv
`timescale 1ns/1ps
module sim_down_deser;
  localparam int W = 4;

  logic clk = 1'b0, rst_n = 1'b1, sdi = 1'b0, ddr_mode = 1'b0, up_half = 1'b0;
  logic [W-1:0] pword;
  logic pclk, refclk;
  int checks = 0, errors = 0;
  logic stream [0:255];

  always #2.5 clk = ~clk;

  down_deser #(.WORD_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .sdi(sdi), .ddr_mode(ddr_mode),
    .up_half(up_half), .pword(pword), .pclk(pclk), .refclk(refclk)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic fill(int pat);
    for (int i = 0; i < 256; i++)
      case (pat)
        0: stream[i] = (i % 3 == 0);
        1: stream[i] = (((i * 5) + (i / 7)) % 4) < 2;
        default: stream[i] = ((i / 4) % 2 == 0) ? (i % 2 == 0) : (i % 4 != 1);
      endcase
  endtask

  // expectations after clock edge p (p = 0 is the first edge after release)
  function automatic logic [W-1:0] exp_word(int p);
    int j;
    if (p < 3) return '0;
    j = (p + 1) / 4 - 1;
    return {stream[4*j], stream[4*j+1], stream[4*j+2], stream[4*j+3]};
  endfunction

  function automatic logic exp_pclk(bit dm, int p);
    if (dm) return ((p + 3) / 4) % 2 == 1;
    return (p % 4) < 2;
  endfunction

  function automatic logic exp_ref(bit uh, int p);
    if (uh) return ((p + 1) / 4) % 2 == 0;
    return ((p + 1) % 4) < 2;
  endfunction

  task automatic start(bit dm, bit uh);
    @(negedge clk);
    rst_n = 1'b0; ddr_mode = dm; up_half = uh; sdi = stream[0];
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run(bit dm, bit uh, int n, string wtag);
    logic [W-1:0] pw_prev = '0;
    logic pc_prev = 1'b0;
    for (int p = 0; p < n; p++) begin
      @(posedge clk);
      @(negedge clk);
      check(wtag, "pword", pword, exp_word(p));
      check(dm ? "R5" : "R4", "pclk", pclk, exp_pclk(dm, p));
      check(uh ? "R8" : "R7", "refclk", refclk, exp_ref(uh, p));
      check("R6", "same-edge change", (pword !== pw_prev) && (pclk !== pc_prev), 1'b0);
      pw_prev = pword; pc_prev = pclk;
      sdi = stream[p + 1];
    end
  endtask

  task automatic test_reset_state();
    sdi = 1'b1; ddr_mode = 1'b1;
    repeat (7) @(negedge clk);
    rst_n = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R1", "pword in reset", pword, '0);
      check("R1", "pclk in reset", pclk, 1'b0);
      check("R1", "refclk in reset", refclk, 1'b0);
    end
  endtask

  task automatic test_sdr(int pat, bit uh);
    fill(pat); start(1'b0, uh); run(1'b0, uh, 40, "R2 R3");
  endtask

  task automatic test_ddr(int pat, bit uh);
    fill(pat); start(1'b1, uh); run(1'b1, uh, 40, "R2 R3");
  endtask

  task automatic test_realign();
    fill(2); start(1'b0, 1'b0); run(1'b0, 1'b0, 6, "R3");
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1", "pword after mid reset", pword, '0);
    fill(1); start(1'b0, 1'b0); run(1'b0, 1'b0, 24, "R9");
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    test_reset_state();
    test_sdr(0, 1'b0);
    test_sdr(1, 1'b1);
    test_ddr(2, 1'b0);
    test_ddr(0, 1'b1);
    test_reset_state();
    test_realign();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule